// File: doc/BRIEF.md
# SPI Word FIFO and Interrupt Front End

This block sits between a host register port and a serial shift engine. It buffers outgoing words in a transmit queue and incoming words in a receive queue, eight words deep each by default. Both queues share one data offset: a host write there enqueues a word for transmission, and a host read there dequeues a received word. The shift engine takes transmit words and delivers received words through a single-cycle take/put handshake. Serial timing is handled elsewhere.

A control register holds a fill threshold for each direction and a self-clearing flush bit for each queue. When the receive queue holds at least its threshold, a ready indication is raised and a sticky receive-complete flag is latched. A word arriving while the receive queue is full is dropped and latches a sticky overrun flag. Both flags are cleared by writing ones to a shared status/clear offset. A single interrupt line reports any flag whose enable is set.

Top module: `spi_fifo_front`

## Requirements
- R1: After reset both queues are empty, thresholds and enables are zero, all flags are clear, `irq` is 0, `tx_avail` is 0, and every register reads 0.
- R2: A host write to offset 4 (data) enqueues `host_wdata`. `tx_avail` is 1 while the transmit queue holds a word. `tx_word` shows the oldest word, and a `tx_take` pulse removes it, so words leave in write order.
- R3: A data write while the transmit queue holds DEPTH words is dropped, and the queued words are not changed.
- R4: A host read of offset 4 returns the oldest received word one cycle later and removes it. A read with the receive queue empty returns 0 and leaves the queue unchanged.
- R5: Bit 0 of the status register (offset 1) reads 1 exactly while the receive queue is not empty. All other status bits read 0.
- R6: The control register (offset 0) stores the transmit threshold in bits 11:8 and the receive threshold in bits 3:0, and reads them back. Writing 1 to bit 12 empties the transmit queue and writing 1 to bit 4 empties the receive queue. Bits 12 and 4 read back as 0.
- R7: With a nonzero receive threshold, bit 9 of offset 3 reads 1 while the receive level is at least the threshold. Bit 3 (receive complete) is set when that condition becomes true and stays set until cleared. A threshold of 0 never raises either bit.
- R8: A `rx_put` while the receive queue holds DEPTH words drops the word and sets bit 0 of offset 3 (overrun), which stays set until cleared.
- R9: A write to offset 3 clears bit 3 where the written bit 3 is 1 and bit 0 where the written bit 0 is 1. Written zeros leave the flags as they are, and bit 4 of the write has no visible effect. A flag event in the same cycle as its clear keeps the flag set.
- R10: The interrupt enable register (offset 2) holds bit 3 (receive complete) and bit 0 (overrun). `irq` is the registered OR of each flag ANDed with its enable, and `irq` is 0 when both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after `host_rd` |
| tx_avail | output | 1 | Transmit queue not empty |
| tx_word | output | DW | Oldest transmit word |
| tx_take | input | 1 | Engine removes the oldest transmit word |
| rx_word | input | DW | Word received by the engine |
| rx_put | input | 1 | Engine delivers `rx_word` |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume the host issues at most one of `host_wr` and `host_rd` per cycle. They also assume the engine pulses `tx_take` only while `tx_avail` is 1. Under these assumptions a dropped write or an empty read is a deliberate probe and not a protocol clash. The bench drives every host access and engine pulse from tasks that hold one strobe for exactly one cycle at a time. It only takes transmit words after it has confirmed `tx_avail`. Deliberate overflow and empty reads are made through the normal strobes, so the drop and zero-return paths are exercised without breaking these rules.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int OFS_W = 3;
  localparam logic [OFS_W-1:0] A_CTRL = 3'd0;
  localparam logic [OFS_W-1:0] A_STAT = 3'd1;
  localparam logic [OFS_W-1:0] A_IEN  = 3'd2;
  localparam logic [OFS_W-1:0] A_IST  = 3'd3;
  localparam logic [OFS_W-1:0] A_DATA = 3'd4;

  localparam int THR_W    = 4;
  localparam int B_TXTH   = 8;
  localparam int B_RXTH   = 0;
  localparam int B_TXFL   = 12;
  localparam int B_RXFL   = 4;
  localparam int B_RNE    = 0;
  localparam int B_IRDY   = 9;
  localparam int B_ICMP   = 3;
  localparam int B_IOVR   = 0;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  pdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign head    = mem[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= pdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      if (push_ok && !pop_ok)      level <= level + 1'b1;
      else if (pop_ok && !push_ok) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/spi_fe_flags.sv
module spi_fe_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic       rdy_now,
  input  logic       ovr_evt,
  input  logic       clr_cmpl,
  input  logic       clr_ovr,
  input  logic [1:0] ien,
  output logic       rdy_q,
  output logic       cmpl,
  output logic       ovr,
  output logic       irq
);
  // ien[1] enables receive complete, ien[0] enables overrun
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q <= 1'b0;
      cmpl  <= 1'b0;
      ovr   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      rdy_q <= rdy_now;
      cmpl  <= (rdy_now && !rdy_q) || (cmpl && !clr_cmpl);
      ovr   <= ovr_evt || (ovr && !clr_ovr);
      irq   <= (cmpl && ien[1]) || (ovr && ien[0]);
    end
  end
endmodule

// File: rtl/spi_fifo_front.sv
module spi_fifo_front
  import spi_fe_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [OFS_W-1:0] host_addr,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  output logic             tx_avail,
  output logic [DW-1:0]    tx_word,
  input  logic             tx_take,
  input  logic [DW-1:0]    rx_word,
  input  logic             rx_put,
  output logic             irq
);
  logic [THR_W-1:0] tx_thr, rx_thr;
  logic [1:0]       ie_q;
  logic [LW-1:0]    tx_level, rx_level;
  logic             tx_empty, tx_full, rx_empty, rx_full;
  logic [DW-1:0]    rx_head;
  logic             rdy_now, rdy_q, cmpl_flag, ovr_flag;

  wire wr_ctrl = host_wr && (host_addr == A_CTRL);
  wire wr_ien  = host_wr && (host_addr == A_IEN);
  wire wr_ist  = host_wr && (host_addr == A_IST);
  wire wr_data = host_wr && (host_addr == A_DATA);
  wire rd_data = host_rd && (host_addr == A_DATA);

  spi_word_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst),
    .flush(wr_ctrl && host_wdata[B_TXFL]),
    .push(wr_data), .pdata(host_wdata[DW-1:0]),
    .pop(tx_take), .head(tx_word),
    .level(tx_level), .empty(tx_empty), .full(tx_full)
  );

  spi_word_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst),
    .flush(wr_ctrl && host_wdata[B_RXFL]),
    .push(rx_put), .pdata(rx_word),
    .pop(rd_data), .head(rx_head),
    .level(rx_level), .empty(rx_empty), .full(rx_full)
  );

  assign tx_avail = !tx_empty;
  assign rdy_now  = (rx_thr != '0) && (int'(rx_level) >= int'(rx_thr));

  spi_fe_flags u_flags (
    .clk(clk), .rst(rst),
    .rdy_now(rdy_now),
    .ovr_evt(rx_put && rx_full),
    .clr_cmpl(wr_ist && host_wdata[B_ICMP]),
    .clr_ovr(wr_ist && host_wdata[B_IOVR]),
    .ien(ie_q),
    .rdy_q(rdy_q), .cmpl(cmpl_flag), .ovr(ovr_flag), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_thr <= '0;
      rx_thr <= '0;
      ie_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        tx_thr <= host_wdata[B_TXTH +: THR_W];
        rx_thr <= host_wdata[B_RXTH +: THR_W];
      end
      if (wr_ien) ie_q <= {host_wdata[B_ICMP], host_wdata[B_IOVR]};
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (host_addr)
      A_CTRL: begin
        rd_mux[B_TXTH +: THR_W] = tx_thr;
        rd_mux[B_RXTH +: THR_W] = rx_thr;
      end
      A_STAT: rd_mux[B_RNE] = !rx_empty;
      A_IEN: begin
        rd_mux[B_ICMP] = ie_q[1];
        rd_mux[B_IOVR] = ie_q[0];
      end
      A_IST: begin
        rd_mux[B_IRDY] = rdy_q;
        rd_mux[B_ICMP] = cmpl_flag;
        rd_mux[B_IOVR] = ovr_flag;
      end
      A_DATA: if (!rx_empty) rd_mux[DW-1:0] = rx_head;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end
endmodule

// File: rtl/spi_fifo_front_chk.sv
module spi_fifo_front_chk
  import spi_fe_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             host_wr,
  input logic             host_rd,
  input logic [OFS_W-1:0] host_addr,
  input logic [31:0]      host_wdata,
  input logic [31:0]      host_rdata,
  input logic             tx_take,
  input logic             rx_put,
  input logic             irq,
  input logic [LW-1:0]    tx_level,
  input logic [LW-1:0]    rx_level,
  input logic [1:0]       ie_q,
  input logic             ovr_flag
);
  a_r3_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == A_DATA && tx_level == LW'(DEPTH) && !tx_take)
      |=> (tx_level == LW'(DEPTH)));

  a_r4_empty_pop_zero: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == A_DATA && rx_level == '0 && !rx_put)
      |=> (host_rdata == '0 && rx_level == '0));

  a_r4_rx_level_bound: assert property (@(posedge clk) disable iff (rst)
    int'(rx_level) <= DEPTH);

  a_r6_rx_flush_empties: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == A_CTRL && host_wdata[B_RXFL]) |=> (rx_level == '0));

  a_r8_overrun_latched: assert property (@(posedge clk) disable iff (rst)
    (rx_put && rx_level == LW'(DEPTH)) |=> ovr_flag);

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ie_q != 2'b00));
endmodule

bind spi_fifo_front spi_fifo_front_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .tx_take(tx_take), .rx_put(rx_put), .irq(irq),
  .tx_level(tx_level), .rx_level(rx_level), .ie_q(ie_q), .ovr_flag(ovr_flag)
);

// File: tb/tb_spi_fifo_front.sv
module tb_spi_fifo_front;
  localparam int DW = 32;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0]    host_addr = '0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;
  logic          tx_avail, tx_take = 1'b0;
  logic [DW-1:0] tx_word, rx_word = '0;
  logic          rx_put = 1'b0;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_fifo_front #(.DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_avail(tx_avail), .tx_word(tx_word), .tx_take(tx_take),
    .rx_word(rx_word), .rx_put(rx_put), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
  endtask

  task automatic put(input logic [31:0] d);
    @(negedge clk); rx_put = 1'b1; rx_word = d;
    @(negedge clk); rx_put = 1'b0;
  endtask

  task automatic take(input string req, input logic [31:0] exp);
    @(negedge clk);
    chk({req, " tx_avail"}, 32'(tx_avail), 32'd1);
    chk({req, " tx_word"}, tx_word, exp);
    tx_take = 1'b1;
    @(negedge clk); tx_take = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 status", v, 0);
    rd(3'd2, v); chk("R1 ien", v, 0);
    rd(3'd3, v); chk("R1 ist", v, 0);
    rd(3'd4, v); chk("R1 data", v, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 tx_avail", 32'(tx_avail), 0);
  endtask

  task automatic t_tx_order;
    for (int i = 0; i < 3; i++) wr(3'd4, 32'hA000 + 32'(i));
    for (int i = 0; i < 3; i++) take("R2 order", 32'hA000 + 32'(i));
    @(negedge clk); chk("R2 drained", 32'(tx_avail), 0);
  endtask

  task automatic t_tx_full;
    for (int i = 0; i < DEPTH + 1; i++) wr(3'd4, 32'h100 + 32'(i));
    for (int i = 0; i < DEPTH; i++) take("R3 kept", 32'h100 + 32'(i));
    @(negedge clk); chk("R3 extra dropped", 32'(tx_avail), 0);
  endtask

  task automatic t_rx_pop;
    logic [31:0] v;
    put(32'h11); put(32'h22); put(32'h33);
    rd(3'd1, v); chk("R5 not empty", v, 32'h1);
    rd(3'd4, v); chk("R4 pop1", v, 32'h11);
    rd(3'd4, v); chk("R4 pop2", v, 32'h22);
    rd(3'd4, v); chk("R4 pop3", v, 32'h33);
    rd(3'd1, v); chk("R5 empty", v, 32'h0);
    rd(3'd4, v); chk("R4 empty read zero", v, 32'h0);
    put(32'hAB);
    rd(3'd4, v); chk("R4 pointers kept", v, 32'hAB);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(3'd0, 32'h0000_1513);
    rd(3'd0, v); chk("R6 thresholds readback", v, 32'h0000_0503);
    put(32'h1); put(32'h2);
    wr(3'd4, 32'h77); wr(3'd4, 32'h78);
    wr(3'd0, 32'h0000_0513);
    rd(3'd1, v); chk("R6 rx flush", v, 32'h0);
    chk("R6 tx untouched by rx flush", 32'(tx_avail), 1);
    wr(3'd0, 32'h0000_1503);
    @(negedge clk); chk("R6 tx flush", 32'(tx_avail), 0);
    rd(3'd4, v); chk("R6 rx stays empty", v, 32'h0);
  endtask

  task automatic t_cmpl;
    logic [31:0] v;
    wr(3'd0, 32'h0000_0003);
    wr(3'd2, 32'h0000_0008);
    rd(3'd2, v); chk("R10 ien readback", v, 32'h8);
    put(32'h5); put(32'h6); idle(3);
    rd(3'd3, v); chk("R7 below threshold", v, 32'h0);
    chk("R10 irq idle", 32'(irq), 0);
    put(32'h7); idle(3);
    rd(3'd3, v); chk("R7 ready and complete", v, 32'h208);
    chk("R10 irq on complete", 32'(irq), 1);
    rd(3'd4, v); idle(2);
    rd(3'd3, v); chk("R7 complete sticky", v, 32'h008);
    wr(3'd3, 32'h0000_0011); idle(2);
    rd(3'd3, v); chk("R9 zero bit keeps flag", v, 32'h008);
    wr(3'd3, 32'h0000_0008); idle(2);
    rd(3'd3, v); chk("R9 clear complete", v, 32'h0);
    chk("R10 irq after clear", 32'(irq), 0);
    wr(3'd0, 32'h0000_0010);
    put(32'h1); put(32'h2); put(32'h3); idle(3);
    rd(3'd3, v); chk("R7 zero threshold inert", v, 32'h0);
    wr(3'd0, 32'h0000_0010);
  endtask

  task automatic t_ovr;
    logic [31:0] v;
    wr(3'd2, 32'h0);
    for (int i = 0; i < DEPTH + 1; i++) put(32'h200 + 32'(i));
    idle(3);
    rd(3'd3, v); chk("R8 overrun flag", v, 32'h1);
    chk("R10 irq masked", 32'(irq), 0);
    wr(3'd2, 32'h1); idle(3);
    chk("R10 irq on overrun", 32'(irq), 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(3'd4, v); chk("R8 stored words", v, 32'h200 + 32'(i));
    end
    rd(3'd4, v); chk("R8 extra word dropped", v, 32'h0);
    wr(3'd3, 32'h0000_0011); idle(2);
    rd(3'd3, v); chk("R9 clear overrun", v, 32'h0);
    chk("R10 irq low", 32'(irq), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_tx_order();
    t_tx_full();
    t_rx_pop();
    t_ctrl();
    t_cmpl();
    t_ovr();
    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule